// File: doc/BRIEF.md
# I2C Byte Shift Engine with Own-Address Recognition

This block moves one byte at a time between software and an I2C bus it shares with other masters. It watches SCL and SDA on one of two selectable pin pairs, finds START and STOP conditions, and shifts bits in on SCL. When software has loaded a byte, it drives that byte onto SDA through open-drain enables. A control register picks the enable state, the addressing options, the pin routing and the number of bits in the next transfer. When a transfer's last bit has shifted, an active-low pending flag drops and SCL is held low until software writes the data register again.

After every START the first byte is taken as an address. It is compared against a programmable own-address value, either on its upper seven bits or on all eight. A byte of all zeros is a general call. If neither kind of match occurs, the engine ignores the bus until the next START. A free-format mode skips the comparison and treats every addressed byte as accepted.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, and at any time the enable bit (control bit 7) is 0, all four pin enables are 0, `irq_n` is 1, and `busy` and `arb_lost` are 0. START conditions and `arb_lost_i` have no effect while the block is disabled.
- R2: While disabled, a data-register write does not change `rx_data`.
- R3: A START sets `busy` and clears the count field (control bits 2:0) to 000, leaving the other control bits unchanged. A STOP clears `busy`.
- R4: For a data transfer, a count field value n of 1 to 7 gives n bits and 000 gives 8 bits. The shifts happen on SCL falling edges, MSB first, into bit 0 of `rx_data`. `irq_n` falls after the n-th bit and not earlier.
- R5: The address byte after a START is always 8 bits, whatever count was programmed before the START.
- R6: With format bit (control bit 6) 0 and wide bit (control bit 5) 0, the address byte matches when its bits 7:1 equal `own_addr[7:1]`. Bit 0 is ignored. A match sets `addr_hit` and drops `irq_n`.
- R7: With the wide bit 1, all 8 address bits must equal `own_addr` to match.
- R8: With the format bit 0, an address byte of 0x00 sets `gen_call` and drops `irq_n`.
- R9: With the format bit 0, an address byte that neither matches nor is 0x00 raises no interrupt. Later bytes are then ignored until the next START.
- R10: With the format bit 1, the address byte always drops `irq_n`, and `addr_hit` and `gen_call` stay 0.
- R11: On an accepted transfer, the SDA enable is 1 exactly while the current MSB of the loaded byte is 0. The bus therefore carries the written byte MSB first, and the enable changes only while SCL is low.
- R12: From the interrupt until the next data-register write, the selected SCL enable is 1. A data-register write sets `irq_n` back to 1 and clears `arb_lost`.
- R13: Control bit 4 selects SCL pair B and control bit 3 selects SDA pair B. The unselected pair is never driven, and its activity is ignored.
- R14: A pulse on `arb_lost_i` while enabled sets `arb_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value: [7] enable, [6] free format, [5] wide compare, [4] SCL pair B, [3] SDA pair B, [2:0] count |
| ctl_rdata | output | 8 | Current control register |
| own_addr | input | 8 | Own address for comparison |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte to load into the shift register |
| rx_data | output | 8 | Shift register contents |
| arb_lost_i | input | 1 | Arbitration-lost pulse from outside logic |
| scl_a_i | input | 1 | SCL level, pair A |
| scl_b_i | input | 1 | SCL level, pair B |
| sda_a_i | input | 1 | SDA level, pair A |
| sda_b_i | input | 1 | SDA level, pair B |
| scl_a_oe | output | 1 | Pull SCL low, pair A |
| scl_b_oe | output | 1 | Pull SCL low, pair B |
| sda_a_oe | output | 1 | Pull SDA low, pair A |
| sda_b_oe | output | 1 | Pull SDA low, pair B |
| irq_n | output | 1 | Pending interrupt, active low |
| busy | output | 1 | Bus busy between START and STOP |
| arb_lost | output | 1 | Arbitration lost flag |
| gen_call | output | 1 | General call seen in the last address byte |
| addr_hit | output | 1 | Own address matched in the last address byte |

## Verification
The hardest state to reach is a non-default count running on a byte after an accepted address. To get there, the bench must complete a START and a matching 8-bit address, answer the SCL hold by rewriting the control register and the data register, and only then clock a short transfer. The bench's bus master obeys the hold on SCL, so it naturally stalls at each interrupt. A seeded random loop then picks, for each frame, the own address and the address kind (exact, bit-0 flipped, zero, random), the format, width and pair selection, the count and the direction. Each outcome is compared against bench functions.

// File: rtl/i2c_be_pkg.sv
package i2c_be_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam int BITS_W  = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic             en;
        logic             free;
        logic             wide;
        logic             scl_b;
        logic             sda_b;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    typedef struct packed {
        ctl_t              ctl;
        logic [BYTE_W-1:0] shift;
        logic              samp;
        logic              samp_vld;
        logic [BITS_W-1:0] bits;
        logic              addr_ph;
        logic              engaged;
        logic              pin_n;
        logic              busy;
        logic              al;
        logic              gc;
        logic              hit;
        logic              hold;
    } eng_t;
endpackage

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] own,
    input  logic         wide,
    output logic         hit,
    output logic         gc
);
    always_comb begin
        if (wide) hit = (rx_byte == own);
        else      hit = (rx_byte[W-1:1] == own[W-1:1]);
        gc = (rx_byte == '0);
    end
endmodule

// File: rtl/i2c_pin_route.sv
module i2c_pin_route #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_scl_b,
    input  logic sel_sda_b,
    input  logic scl_a_i,
    input  logic scl_b_i,
    input  logic sda_a_i,
    input  logic sda_b_i,
    input  logic scl_drv,
    input  logic sda_drv,
    output logic scl_a_oe,
    output logic scl_b_oe,
    output logic sda_a_oe,
    output logic sda_b_oe,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_sy_d, scl_sy_q, sda_sy_d, sda_sy_q;
    logic              scl_pv_d, scl_pv_q, sda_pv_d, sda_pv_q;
    logic [1:0]        scl_oe, sda_oe;
    logic              scl_raw, sda_raw;

    always_comb begin
        scl_raw  = sel_scl_b ? scl_b_i : scl_a_i;
        sda_raw  = sel_sda_b ? sda_b_i : sda_a_i;
        scl_sy_d = {scl_sy_q[STAGES-2:0], scl_raw};
        sda_sy_d = {sda_sy_q[STAGES-2:0], sda_raw};
        scl_pv_d = scl_sy_q[STAGES-1];
        sda_pv_d = sda_sy_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sy_q <= '1;
            sda_sy_q <= '1;
            scl_pv_q <= 1'b1;
            sda_pv_q <= 1'b1;
        end else begin
            scl_sy_q <= scl_sy_d;
            sda_sy_q <= sda_sy_d;
            scl_pv_q <= scl_pv_d;
            sda_pv_q <= sda_pv_d;
        end
    end

    assign scl_s     = scl_sy_q[STAGES-1];
    assign sda_s     = sda_sy_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_pv_q;
    assign scl_fall  = ~scl_s & scl_pv_q;
    assign start_evt = scl_s & scl_pv_q & sda_pv_q & ~sda_s;
    assign stop_evt  = scl_s & scl_pv_q & ~sda_pv_q & sda_s;

    for (genvar p = 0; p < 2; p++) begin : g_pair
        assign scl_oe[p] = scl_drv & (sel_scl_b == p[0]);
        assign sda_oe[p] = sda_drv & (sel_sda_b == p[0]);
    end

    assign scl_a_oe = scl_oe[0];
    assign scl_b_oe = scl_oe[1];
    assign sda_a_oe = sda_oe[0];
    assign sda_b_oe = sda_oe[1];

    p_one_pair_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({scl_a_oe, scl_b_oe}) <= 1 && $countones({sda_a_oe, sda_b_oe}) <= 1);
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_be_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic [7:0] own_addr,
    input  logic       dat_wr,
    input  logic [7:0] dat_wdata,
    output logic [7:0] rx_data,
    input  logic       arb_lost_i,
    input  logic       scl_a_i,
    input  logic       scl_b_i,
    input  logic       sda_a_i,
    input  logic       sda_b_i,
    output logic       scl_a_oe,
    output logic       scl_b_oe,
    output logic       sda_a_oe,
    output logic       sda_b_oe,
    output logic       irq_n,
    output logic       busy,
    output logic       arb_lost,
    output logic       gen_call,
    output logic       addr_hit
);
    localparam logic [BITS_W-1:0] FULL = BITS_W'(BYTE_W);

    eng_t              q, d;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              scl_drv, sda_drv, cmp_hit, cmp_gc, fire;
    logic [BYTE_W-1:0] nxt_shift;

    assign nxt_shift = {q.shift[BYTE_W-2:0], q.samp};
    assign scl_drv   = q.ctl.en & q.hold;
    assign sda_drv   = q.ctl.en & q.engaged & (q.bits != '0) & ~q.shift[BYTE_W-1];

    i2c_pin_route #(.STAGES(SYNC_STAGES)) u_route (
        .clk(clk), .rst_n(rst_n),
        .sel_scl_b(q.ctl.scl_b), .sel_sda_b(q.ctl.sda_b),
        .scl_a_i(scl_a_i), .scl_b_i(scl_b_i), .sda_a_i(sda_a_i), .sda_b_i(sda_b_i),
        .scl_drv(scl_drv), .sda_drv(sda_drv),
        .scl_a_oe(scl_a_oe), .scl_b_oe(scl_b_oe), .sda_a_oe(sda_a_oe), .sda_b_oe(sda_b_oe),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2c_addr_cmp #(.W(BYTE_W)) u_cmp (
        .rx_byte(nxt_shift), .own(own_addr), .wide(q.ctl.wide),
        .hit(cmp_hit), .gc(cmp_gc)
    );

    always_comb begin
        d    = q;
        fire = 1'b0;
        if (ctl_wr) d.ctl = ctl_t'(ctl_wdata);
        if (!d.ctl.en) begin
            d.pin_n    = 1'b1;
            d.busy     = 1'b0;
            d.al       = 1'b0;
            d.bits     = '0;
            d.hold     = 1'b0;
            d.engaged  = 1'b0;
            d.addr_ph  = 1'b0;
            d.samp_vld = 1'b0;
        end else begin
            if (dat_wr) begin
                d.shift    = dat_wdata;
                d.pin_n    = 1'b1;
                d.hold     = 1'b0;
                d.al       = 1'b0;
                d.samp_vld = 1'b0;
                d.bits     = (d.ctl.cnt == '0) ? FULL : BITS_W'(d.ctl.cnt);
            end
            if (arb_lost_i) d.al = 1'b1;
            if (scl_rise && q.bits != '0) begin
                d.samp     = sda_s;
                d.samp_vld = 1'b1;
            end
            if (scl_fall && q.bits != '0 && q.samp_vld) begin
                d.shift    = nxt_shift;
                d.bits     = q.bits - 1'b1;
                d.samp_vld = 1'b0;
                if (q.bits == BITS_W'(1)) begin
                    if (q.addr_ph) begin
                        d.addr_ph = 1'b0;
                        d.gc      = ~q.ctl.free & cmp_gc;
                        d.hit     = ~q.ctl.free & cmp_hit;
                        d.engaged = q.ctl.free | cmp_gc | cmp_hit;
                        fire      = d.engaged;
                    end else begin
                        fire = q.engaged;
                    end
                    if (fire) begin
                        d.pin_n = 1'b0;
                        d.hold  = 1'b1;
                    end
                end
            end
            if (start_evt) begin
                d.busy     = 1'b1;
                d.ctl.cnt  = '0;
                d.bits     = FULL;
                d.addr_ph  = 1'b1;
                d.engaged  = 1'b0;
                d.gc       = 1'b0;
                d.hit      = 1'b0;
                d.shift    = '1;
                d.pin_n    = 1'b1;
                d.hold     = 1'b0;
                d.samp_vld = 1'b0;
            end
            if (stop_evt) begin
                d.busy     = 1'b0;
                d.bits     = '0;
                d.addr_ph  = 1'b0;
                d.engaged  = 1'b0;
                d.hold     = 1'b0;
                d.samp_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.pin_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ctl_rdata = q.ctl;
    assign rx_data   = q.shift;
    assign irq_n     = q.pin_n;
    assign busy      = q.busy;
    assign arb_lost  = q.al;
    assign gen_call  = q.gc;
    assign addr_hit  = q.hit;

    p_forced_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctl.en |-> (q.pin_n && !q.busy && !q.al && q.bits == '0));

    p_count_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && q.ctl.en && !ctl_wr) |=> (q.ctl.cnt == '0 && q.busy));

    p_bits_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.bits <= FULL);

    p_irq_only_engaged_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.pin_n) |-> (q.engaged && q.hold));

    p_sda_moves_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_drv != $past(sda_drv)) && q.ctl.en && $past(q.ctl.en)
         && !$past(dat_wr || ctl_wr || start_evt || stop_evt)) |-> !scl_s);
endmodule

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, dat_wr = 1'b0, arb_lost_i = 1'b0;
    logic [7:0] ctl_wdata = '0, dat_wdata = '0, own_addr = '0;
    logic [7:0] ctl_rdata, rx_data;
    logic       scl_ma = 1'b1, sda_ma = 1'b1, scl_mb = 1'b1, sda_mb = 1'b1;
    logic       scl_a_oe, scl_b_oe, sda_a_oe, sda_b_oe;
    logic       irq_n, busy, arb_lost, gen_call, addr_hit;
    logic       scl_a, scl_b, sda_a, sda_b;
    logic       use_b_scl = 1'b0, use_b_sda = 1'b0;
    int         tests = 0, fails = 0;

    always #5 clk = ~clk;

    assign scl_a = scl_ma & ~scl_a_oe;
    assign scl_b = scl_mb & ~scl_b_oe;
    assign sda_a = sda_ma & ~sda_a_oe;
    assign sda_b = sda_mb & ~sda_b_oe;

    i2c_byte_engine i_i2c_byte_engine (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .own_addr(own_addr), .dat_wr(dat_wr), .dat_wdata(dat_wdata), .rx_data(rx_data),
        .arb_lost_i(arb_lost_i), .scl_a_i(scl_a), .scl_b_i(scl_b), .sda_a_i(sda_a), .sda_b_i(sda_b),
        .scl_a_oe(scl_a_oe), .scl_b_oe(scl_b_oe), .sda_a_oe(sda_a_oe), .sda_b_oe(sda_b_oe),
        .irq_n(irq_n), .busy(busy), .arb_lost(arb_lost), .gen_call(gen_call), .addr_hit(addr_hit)
    );

    function automatic logic exp_match(logic [7:0] a, logic [7:0] own, logic wide);
        return wide ? (a == own) : (a[7:1] == own[7:1]);
    endfunction

    function automatic logic [7:0] exp_shift(logic [7:0] old, logic [7:0] bits, int n);
        logic [7:0] r = old;
        for (int i = n - 1; i >= 0; i--) r = {r[6:0], bits[i]};
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (10) @(negedge clk);
    endtask

    task automatic m_scl(logic v);
        if (use_b_scl) scl_mb = v; else scl_ma = v;
    endtask

    task automatic m_sda(logic v);
        if (use_b_sda) sda_mb = v; else sda_ma = v;
    endtask

    function automatic logic bus_scl();
        return use_b_scl ? scl_b : scl_a;
    endfunction

    function automatic logic bus_sda();
        return use_b_sda ? sda_b : sda_a;
    endfunction

    task automatic scl_high();
        m_scl(1'b1);
        while (!bus_scl()) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda(1'b1); m_scl(1'b1); half();
        m_sda(1'b0); half();
        m_scl(1'b0); half();
    endtask

    task automatic m_stop();
        m_sda(1'b0); half();
        scl_high(); half();
        m_sda(1'b1); half();
    endtask

    task automatic m_bit(logic b);
        m_sda(b); half();
        scl_high(); half();
        m_scl(1'b0); half();
    endtask

    task automatic m_read(output logic b);
        m_sda(1'b1); half();
        scl_high(); half();
        b = bus_sda();
        m_scl(1'b0); half();
    endtask

    task automatic m_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_bit(v[i]);
    endtask

    task automatic wr_ctl(logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_dat(logic [7:0] v);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
        @(negedge clk); dat_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] own, addr, data, rb, ctl, got;
        logic       wide, free, sb, db, fire, tx, b;
        int         n, kind;
        void'($urandom(32'h1C2B3A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 reset irq_n", irq_n, 1);
        check("R1 reset busy/al", {busy, arb_lost}, 0);
        check("R1 reset oe", {scl_a_oe, scl_b_oe, sda_a_oe, sda_b_oe}, 0);
        // R2 data write ignored while disabled
        wr_dat(8'h5A);
        check("R2 rx unchanged", rx_data, 8'h00);
        // R1 START and arb pulse ignored while disabled
        m_start();
        check("R1 start ignored busy", busy, 0);
        @(negedge clk); arb_lost_i = 1'b1; @(negedge clk); arb_lost_i = 1'b0;
        check("R1 arb ignored", arb_lost, 0);
        m_stop();

        // R5 address always 8 bits; R3 count cleared
        own_addr = 8'hA4;
        wr_ctl(8'h83);
        m_start();
        check("R3 busy on start", busy, 1);
        check("R3 count cleared", ctl_rdata, 8'h80);
        for (int i = 7; i >= 1; i--) m_bit(addr_bit(8'hA5, i));
        check("R5 no irq after 7 bits", irq_n, 1);
        m_bit(1'b1);
        check("R5 irq after 8 bits", irq_n, 0);
        check("R6 bit0 ignored hit", addr_hit, 1);
        check("R12 scl held", scl_a_oe, 1);
        wr_ctl(8'h83);
        wr_dat(8'hFF);
        check("R12 release irq_n", irq_n, 1);
        check("R12 scl released", scl_a_oe, 0);
        m_bit(1'b1); m_bit(1'b0);
        check("R4 no irq after 2 of 3", irq_n, 1);
        m_bit(1'b1);
        check("R4 irq after 3", irq_n, 0);
        check("R4 rx after 3", rx_data, exp_shift(8'hFF, 8'h05, 3));
        wr_dat(8'hFF);
        m_stop();
        check("R3 busy cleared by stop", busy, 0);

        // random frames
        for (int it = 0; it < 24; it++) begin
            own  = 8'($urandom);
            wide = 1'($urandom);
            free = ($urandom % 4) == 0;
            sb   = 1'($urandom);
            db   = 1'($urandom);
            kind = $urandom % 4;
            case (kind)
                0: addr = own;
                1: addr = {own[7:1], ~own[0]};
                2: addr = 8'h00;
                default: addr = 8'($urandom);
            endcase
            n   = $urandom % 8;
            ctl = {1'b1, free, wide, sb, db, 3'(n)};
            if (n == 0) n = 8;
            use_b_scl = sb; use_b_sda = db;
            own_addr = own;
            wr_ctl(ctl);
            m_start();
            check("R3 count cleared rnd", ctl_rdata[2:0], 0);
            m_byte(addr);
            fire = free | (addr == 8'h00) | exp_match(addr, own, wide);
            check(free ? "R10 irq" : (wide ? "R7 irq" : "R6 irq"), irq_n, !fire);
            check(free ? "R10 hit" : (wide ? "R7 hit" : "R6 hit"), addr_hit, !free & exp_match(addr, own, wide));
            check(free ? "R10 gc" : "R8 gc", gen_call, !free & (addr == 8'h00));
            if (fire) begin
                check("R12 selected scl held", sb ? scl_b_oe : scl_a_oe, 1);
                check("R13 other scl idle", sb ? scl_a_oe : scl_b_oe, 0);
                wr_ctl(ctl);
                tx = 1'($urandom);
                if (tx) begin
                    data = 8'($urandom);
                    wr_dat(data);
                    check("R12 irq_n set by write", irq_n, 1);
                    got = '0;
                    for (int i = 0; i < n; i++) begin
                        m_read(b);
                        got = {got[6:0], b};
                    end
                    check("R11 bus bits", got, 8'(data >> (8 - n)));
                    check("R13 other sda idle", db ? sda_a_oe : sda_b_oe, 0);
                end else begin
                    wr_dat(8'hFF);
                    rb = 8'($urandom);
                    for (int i = n - 1; i >= 1; i--) m_bit(rb[i]);
                    check("R4 no early irq", irq_n, 1);
                    m_bit(rb[0]);
                    check("R4 rx value", rx_data, exp_shift(8'hFF, rb, n));
                end
                check("R4 irq after n", irq_n, 0);
                wr_dat(8'hFF);
            end else begin
                wr_ctl({ctl[7:3], 3'b000});
                wr_dat(8'hFF);
                m_byte(8'($urandom));
                check("R9 ignored byte", irq_n, 1);
            end
            m_stop();
            check("R3 stop", busy, 0);
        end

        // R13 activity on unselected pair ignored
        use_b_scl = 1'b0; use_b_sda = 1'b0;
        wr_ctl(8'h98);
        m_start();
        check("R13 unselected start ignored", busy, 0);
        m_stop();

        // R14 arbitration flag
        wr_ctl(8'h80);
        @(negedge clk); arb_lost_i = 1'b1; @(negedge clk); arb_lost_i = 1'b0;
        @(negedge clk);
        check("R14 arb set", arb_lost, 1);
        wr_dat(8'hFF);
        check("R12 arb cleared by write", arb_lost, 0);

        // R1 disable forces flags mid-frame
        own_addr = 8'h3C;
        m_start();
        m_byte(8'h3C);
        check("R6 exact hit", irq_n, 0);
        wr_ctl(8'h00);
        check("R1 forced irq_n", irq_n, 1);
        check("R1 forced busy", busy, 0);
        check("R1 forced oe", {scl_a_oe, scl_b_oe, sda_a_oe, sda_b_oe}, 0);
        m_stop();
        finish_run();
    end

    function automatic logic addr_bit(logic [7:0] v, int i);
        return v[i];
    endfunction
endmodule